// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit half of a half-duplex synchronous serial port that acts as clock master. Words arrive on a valid/ready write port and land in a one-word holding buffer. When the shift register is empty and transmission is enabled, the buffered word moves into the shift register in one clock cycle. The shift register then drives the data line, least significant bit first, while the block generates the shift clock on a separate clock line.

Each word is 8 bits long, or 9 bits when the ninth-bit mode is selected. The ninth bit and the mode are captured together with the data at the moment of the write. The half period of the shift clock is `div+1` system cycles. The divisor is either the full 16-bit value or only its low byte, chosen by a mode input. The idle level of the clock line can be programmed. If the next word is already in the buffer when a word finishes, it follows without any gap.

The write port uses valid/ready handshaking. `in_ready` is the buffer-empty flag. A beat is taken on a cycle where both `in_valid` and `in_ready` are high. While the buffer is full, `in_ready` stays low and the buffered word is protected. The buffer-empty flag cannot be cleared in any way except by a write. A separate shift-empty status reports whether a word is currently being shifted, and the receive side is told to stay quiet through an inhibit output.

Top module: `sync_tx_master`

## Requirements
- R1: After reset, `buf_empty` and `in_ready` are 1, `shift_empty` is 1, `rx_inhibit` is 0 and `ser_clk` sits at the level of `clk_idle_hi`.
- R2: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `buf_empty` is 0. While the buffer is full, further beats are ignored, and the word that is later transmitted is the one accepted first.
- R3: With `tx_en` high, the shift register empty and the buffer full, the word moves to the shift register on the next edge. After that edge, `buf_empty` is 1 and `shift_empty` is 0.
- R4: Once set, `buf_empty` stays 1 until a beat is accepted, whatever the shifter does.
- R5: Bits go out LSB first. `ser_dat` takes bit k on the edge where `ser_clk` leaves its idle level, and it holds that value until the clock returns to idle.
- R6: Each clock half period lasts `div+1` cycles. When `div_wide` is 1, `div` is `div_val[15:0]`. When it is 0, `div` is `div_val[7:0]`. The first active clock edge comes `div+1` cycles after the transfer edge.
- R7: `ser_clk` equals `clk_idle_hi` whenever no word is being shifted. When `clk_idle_hi` is 1, the active level is 0, and the reverse.
- R8: A beat accepted while `nine_bit` is 1 is sent as 9 bits, the ninth being `in_data[8]`. A beat accepted while `nine_bit` is 0 is sent as 8 bits, from `in_data[7:0]`.
- R9: If the next word is in the buffer when the last bit of a word finishes, it is loaded on that same edge. Active clock edges then keep a uniform spacing of `2*(div+1)` cycles across the word boundary.
- R10: `shift_empty` is 0 exactly while a word is being shifted, and `rx_inhibit` is its complement.
- R11: Driving `tx_en` low aborts the word in progress. On the next cycle `shift_empty` is 1 and `ser_clk` is idle. The buffer keeps its word, and that word is sent once `tx_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low aborts shifting |
| clk_idle_hi | input | 1 | Idle level of the shift clock |
| nine_bit | input | 1 | Ninth-bit mode, captured with each beat |
| div_wide | input | 1 | 1 selects the 16-bit divisor, 0 the low byte |
| div_val | input | 16 | Clock divisor |
| in_valid | input | 1 | Write beat valid |
| in_data | input | 9 | Write data; bit 8 is the ninth bit |
| in_ready | output | 1 | Buffer can accept a beat |
| ser_clk | output | 1 | Shift clock line |
| ser_dat | output | 1 | Serial data line |
| buf_empty | output | 1 | Sticky holding-buffer-empty flag |
| shift_empty | output | 1 | Shift register empty status |
| rx_inhibit | output | 1 | Receive inhibit while shifting |

## Verification
The assertions take for granted that the configuration inputs `clk_idle_hi`, `nine_bit`, `div_wide` and `div_val` change only while the shifter is empty. They also assume that `in_data` holds steady for the single cycle a beat is offered. The stimulus follows these rules. It reprograms the configuration only after the shifter and the buffer have both drained, and it drops `in_valid` right after the accepting edge. The only exception is the back-pressure test, where a beat is deliberately held against a full buffer.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  localparam int unsigned BASE_W = 8;
  localparam int unsigned WORD_W = BASE_W + 1;

  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic              ninth_en;
  } txw_t;
endpackage

// File: rtl/sync_tx_baud.sv
module sync_tx_baud #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wide,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    if (wide) limit = div_val;
    else      limit = {{(DIV_W-NARROW_W){1'b0}}, div_val[NARROW_W-1:0]};
  end

  assign tick = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)    cnt_q <= '0;
    else if (cnt_q >= limit) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R6: the count never moves while the shifter is idle
  p_idle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/sync_tx_hold.sv
module sync_tx_hold
  import sync_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  output logic wr_ready,
  input  txw_t wr_word,
  input  logic take,
  output logic full,
  output txw_t word_q
);
  assign wr_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      word_q <= '0;
    end else if (wr_valid && !full) begin
      full   <= 1'b1;
      word_q <= wr_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  p_take_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  p_fill_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_valid));
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !wr_valid) |=> !full);
  p_keep_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(full)) |-> $stable(word_q));
endmodule

// File: rtl/sync_tx_shift.sv
module sync_tx_shift
  import sync_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic have_word,
  input  txw_t word_in,
  output logic load,
  output logic busy,
  output logic phase,
  output logic dat
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_q;
  logic              last_bit;
  logic              word_end;

  assign last_bit = (cnt_q == last_q);
  assign word_end = busy && tick && phase && last_bit;
  assign load     = en && have_word && (!busy || word_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      dat    <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!en) begin
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      sh_q   <= word_in.bits;
      cnt_q  <= '0;
      last_q <= word_in.ninth_en ? CNT_W'(BASE_W) : CNT_W'(BASE_W - 1);
    end else if (busy && tick) begin
      if (!phase) begin
        phase <= 1'b1;
        dat   <= sh_q[0];
      end else begin
        phase <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_dat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && $past(phase)) |-> $stable(dat));
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !phase));
  p_phase_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> busy);
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master
  import sync_tx_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             clk_idle_hi,
  input  logic             nine_bit,
  input  logic             div_wide,
  input  logic [DIV_W-1:0] div_val,
  input  logic             in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic             in_ready,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             rx_inhibit
);
  txw_t wr_word;
  txw_t held;
  logic full;
  logic load;
  logic busy;
  logic phase;
  logic tick;

  always_comb begin
    wr_word.bits     = nine_bit ? in_data : {1'b0, in_data[BASE_W-1:0]};
    wr_word.ninth_en = nine_bit;
  end

  sync_tx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_word  (wr_word),
    .take     (load),
    .full     (full),
    .word_q   (held)
  );

  sync_tx_baud #(.DIV_W(DIV_W), .NARROW_W(NARROW_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .wide    (div_wide),
    .div_val (div_val),
    .tick    (tick)
  );

  sync_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .tick      (tick),
    .have_word (full),
    .word_in   (held),
    .load      (load),
    .busy      (busy),
    .phase     (phase),
    .dat       (ser_dat)
  );

  assign ser_clk     = clk_idle_hi ^ phase;
  assign buf_empty   = !full;
  assign shift_empty = !busy;
  assign rx_inhibit  = busy;

  p_idle_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk == clk_idle_hi));
  p_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !busy && tx_en) |=> (busy && buf_empty));
  p_gapless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && full && tx_en && tick && phase) |=> $stable(busy));
endmodule

// File: tb/sync_tx_master_test.sv
module sync_tx_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        idle_hi = 1'b0;
  logic        nine = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] div_val = '0;
  logic        in_valid = 1'b0;
  logic [8:0]  in_data = '0;
  logic        in_ready, ser_clk, ser_dat, buf_empty, shift_empty, rx_inhibit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sync_tx_master uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clk_idle_hi(idle_hi),
    .nine_bit(nine), .div_wide(wide), .div_val(div_val),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .buf_empty(buf_empty),
    .shift_empty(shift_empty), .rx_inhibit(rx_inhibit)
  );

  always @(posedge clk) cyc++;

  logic prev_ck = 1'b0;
  int   nrec = 0;
  logic rbit [0:4095];
  int   rcyc [0:4095];

  always @(negedge clk) begin
    if (rst_n && ser_clk != idle_hi && prev_ck == idle_hi && nrec < 4096) begin
      rbit[nrec] = ser_dat;
      rcyc[nrec] = cyc;
      nrec++;
    end
    prev_ck = ser_clk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (shift_empty && buf_empty) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Compare recorded active edges against one or two expected words
  task automatic verify(input int base, input int nw, input logic [8:0] w0,
                        input logic [8:0] w1, input int first, input int d, input int len);
    int got = nrec - base;
    int bad_bit = 0;
    int bad_gap = 0;
    chk("R8", "bit count", got, nw * len);
    if (got == nw * len) begin
      for (int k = 0; k < nw * len; k++) begin
        logic e;
        e = (k < len) ? w0[k] : w1[k - len];
        if (rbit[base + k] !== e) bad_bit++;
        if (k > 0 && rcyc[base + k] - rcyc[base + k - 1] != 2 * (d + 1)) bad_gap++;
      end
      chk("R5", "LSB-first bit errors", bad_bit, 0);
      chk(nw > 1 ? "R9" : "R6", "edge spacing errors", bad_gap, 0);
      chk("R6", "first active edge cycle", rcyc[base], first);
    end
  endtask

  task automatic run_words(input int nw, input logic [8:0] w0, input logic [8:0] w1, input int d);
    int base, c, len;
    len = nine ? 9 : 8;
    base = nrec;
    chk("R7", "idle clock level", ser_clk, idle_hi);
    in_valid = 1'b1; in_data = w0; c = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "buf_empty after accept", buf_empty, 0);
    @(negedge clk);
    chk("R3", "buf_empty after transfer", buf_empty, 1);
    chk("R3", "shift_empty after transfer", shift_empty, 0);
    chk("R10", "rx_inhibit while shifting", rx_inhibit, 1);
    if (nw > 1) begin
      in_valid = 1'b1; in_data = w1;
      @(negedge clk);
      in_valid = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
      chk("R4", "buf_empty sticky mid-word", buf_empty, 1);
    end
    wait_done();
    chk("R10", "rx_inhibit after done", rx_inhibit, 0);
    chk("R4", "in_ready after done", in_ready, 1);
    verify(base, nw, w0, w1, c + 3 + d, d, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "buf_empty", buf_empty, 1);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "shift_empty", shift_empty, 1);
    chk("R1", "rx_inhibit", rx_inhibit, 0);
    chk("R1", "ser_clk idle", ser_clk, idle_hi);

    tx_en = 1'b1;
    // Sweep divisor, polarity and word length
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++)
        for (int n9 = 0; n9 < 2; n9++) begin
          logic [8:0] a, b;
          div_val = 16'(d); wide = 1'b0; idle_hi = p[0]; nine = n9[0];
          @(negedge clk);
          a = 9'((d * 37 + p * 91 + n9 * 13 + 5) * 7);
          b = 9'(~a + 9'(d * 3 + 1));
          run_words(1, a, '0, d);
          run_words(2, b, a, d);
        end

    // R6: narrow mode uses low byte only, wide uses all 16 bits
    idle_hi = 1'b0; nine = 1'b0; div_val = 16'h0102;
    wide = 1'b0; @(negedge clk);
    run_words(1, 9'h0A5, '0, 2);
    wide = 1'b1; @(negedge clk);
    run_words(1, 9'h03C, '0, 258);
    wide = 1'b0; div_val = 16'h0001; nine = 1'b1;
    @(negedge clk);

    // R2: back-pressure while disabled; R11 buffered word survives
    begin
      int base, c;
      tx_en = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = 9'h1C3;
      @(negedge clk);
      in_data = 9'h02E;
      repeat (3) @(negedge clk);
      chk("R2", "buf_empty while full", buf_empty, 0);
      chk("R2", "in_ready while full", in_ready, 0);
      in_valid = 1'b0;
      chk("R11", "shift_empty while disabled", shift_empty, 1);
      base = nrec; c = cyc;
      tx_en = 1'b1;
      wait_done();
      verify(base, 1, 9'h1C3, '0, c + 2 + 1, 1, 9);
    end

    // R11: abort mid-word, buffered word goes after re-enable
    begin
      int base, c;
      nine = 1'b0;
      in_valid = 1'b1; in_data = 9'h0F0;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      in_valid = 1'b1; in_data = 9'h05A;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R11", "shift_empty after abort", shift_empty, 1);
      chk("R11", "ser_clk idle after abort", ser_clk, idle_hi);
      chk("R11", "buffer kept after abort", buf_empty, 0);
      repeat (3) @(negedge clk);
      base = nrec; c = cyc;
      tx_en = 1'b1;
      wait_done();
      verify(base, 1, 9'h05A, '0, c + 2 + 1, 1, 8);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule